// File: doc/BRIEF.md
# Erasable ROM Emulator

This block is a synthesizable stand-in for a 4096 x 8 UV-erasable read-only memory, for use inside a target system or a verification environment. Three control inputs select one of six modes: chip select (active low), output enable (active low) and a flag that stands for the high programming voltage being present. The data bus is bidirectional. The block drives it with the stored byte when it is read, and it listens to the bus while a byte is being programmed. A separate output shows whether the block drives the bus.

Programming works like the real cell. An erased bit reads 1, and a programming pulse can only clear bits. The stored byte therefore becomes the old byte ANDed with the new byte. A programming pulse is chip select held low for a number of clocks. It takes effect only if its length falls inside a parameterised window. A pulse that is too short is ignored. A pulse that is too long writes nothing and raises an error flag. A synchronous erase request sweeps the whole array to all ones, one word per clock, and a busy output is high while the sweep runs.

Top module: `eprom_emu`

## Requirements
- R1: Read mode is voltage flag low, chip select low and output enable low. One clock after the inputs are sampled in this mode, the block drives the bus (`dq_drive` = 1) with the byte stored at the sampled address.
- R2: Standby is chip select high with the voltage flag low. One clock later the block does not drive the bus, whatever output enable is.
- R3: Output disable is voltage flag low, chip select low and output enable high. One clock later the block does not drive the bus.
- R4: Program mode is voltage flag high, chip select low and output enable high. The block does not drive the bus. Address and bus data are captured on the first clock of the pulse. When the pulse ends after N clocks with PULSE_MIN <= N <= PULSE_MAX, the captured byte becomes the old byte AND the captured data.
- R5: Inhibit is voltage flag high with chip select high. The bus is not driven and nothing is written, however long the inhibit lasts.
- R6: Verify is voltage flag high, chip select low and output enable low. One clock later the block drives the stored byte, and nothing is written.
- R7: A program pulse shorter than PULSE_MIN clocks leaves the array unchanged.
- R8: A program pulse longer than PULSE_MAX clocks writes nothing. `pulse_err` goes to 1 on the clock after the pulse ends and returns to 0 on the clock after the next pulse starts.
- R9: An `erase` sampled high while idle raises `busy` for exactly DEPTH clocks. After that, every byte reads 0xFF.
- R10: While `busy` is high, program pulses are ignored, and a new erase request neither restarts nor extends the sweep.
- R11: After reset, `busy`, `pulse_err` and `dq_drive` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low; also the program pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | High when the programming voltage is present |
| addr | input | 12 | Word address |
| dq | inout | 8 | Bidirectional data bus |
| dq_drive | output | 1 | High while the block drives `dq` |
| erase | input | 1 | Synchronous bulk-erase request |
| busy | output | 1 | Erase sweep in progress |
| pulse_err | output | 1 | Last program pulse was too long |

## Verification
The bound checker applies the bus-drive rules on every clock. Standby, output disable and program mode must release the bus, and read and verify must drive it. The checker also confirms that an erase request raises `busy` and that `pulse_err` holds still during a sweep. The AND-only programming, the pulse-length window, the silence of inhibit, the exact sweep length and the blocking of requests during a sweep depend on array contents and pulse history. The bench's reference model is the only thing that shows them, through readback scenarios.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;
    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_OFF,
        MD_PROG,
        MD_INHIBIT,
        MD_VERIFY
    } mode_e;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_emu_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    output mode_e mode
);
    always_comb begin
        if (vpp_hi) begin
            if (ce_n)      mode = MD_INHIBIT;
            else if (oe_n) mode = MD_PROG;
            else           mode = MD_VERIFY;
        end else begin
            if (ce_n)      mode = MD_STANDBY;
            else if (oe_n) mode = MD_OFF;
            else           mode = MD_READ;
        end
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    assign pdata = cells[paddr];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/eprom_prog_ctl.sv
module eprom_prog_ctl
    import eprom_emu_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 8,
    parameter int PULSE_MIN = 4,
    parameter int PULSE_MAX = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          erase,
    input  logic [DW-1:0] pdata,
    output logic [AW-1:0] paddr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          drive,
    output logic          busy,
    output logic          pulse_err
);
    localparam int          CW    = $clog2(PULSE_MAX + 2);
    localparam logic [CW-1:0] C_MIN = CW'(PULSE_MIN);
    localparam logic [CW-1:0] C_MAX = CW'(PULSE_MAX);
    localparam logic [AW-1:0] LAST  = {AW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic          err;
        logic          busy;
        logic [AW-1:0] ptr;
        logic          drv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        waddr = st_q.wa;
        wdata = pdata & st_q.wd;
        st_d.drv = (mode == MD_READ) || (mode == MD_VERIFY);
        if (st_q.busy) begin
            st_d.cnt = '0;
            we       = 1'b1;
            waddr    = st_q.ptr;
            wdata    = '1;
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ptr == LAST) st_d.busy = 1'b0;
        end else begin
            if (mode == MD_PROG) begin
                if (st_q.cnt == '0) begin
                    st_d.wa  = addr;
                    st_d.wd  = din;
                    st_d.err = 1'b0;
                end
                if (st_q.cnt <= C_MAX) st_d.cnt = st_q.cnt + 1'b1;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = '0;
                if (st_q.cnt >= C_MIN && st_q.cnt <= C_MAX) we = 1'b1;
                else if (st_q.cnt > C_MAX) st_d.err = 1'b1;
            end
            if (erase) begin
                st_d.busy = 1'b1;
                st_d.ptr  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paddr     = st_q.wa;
    assign drive     = st_q.drv;
    assign busy      = st_q.busy;
    assign pulse_err = st_q.err;
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
    import eprom_emu_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 8,
    parameter int PULSE_MIN = 4,
    parameter int PULSE_MAX = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          vpp_hi,
    input  logic [AW-1:0] addr,
    inout  wire  [DW-1:0] dq,
    output logic          dq_drive,
    input  logic          erase,
    output logic          busy,
    output logic          pulse_err
);
    mode_e         mode;
    logic          we;
    logic [AW-1:0] waddr, paddr;
    logic [DW-1:0] wdata, pdata, rdata;

    eprom_mode_dec u_dec (
        .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .mode(mode)
    );

    eprom_prog_ctl #(
        .AW(AW), .DW(DW), .PULSE_MIN(PULSE_MIN), .PULSE_MAX(PULSE_MAX)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(dq),
        .erase(erase), .pdata(pdata), .paddr(paddr), .we(we),
        .waddr(waddr), .wdata(wdata), .drive(dq_drive), .busy(busy),
        .pulse_err(pulse_err)
    );

    eprom_array #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .paddr(paddr), .pdata(pdata), .raddr(addr), .rdata(rdata)
    );

    assign dq = dq_drive ? rdata : 'z;
endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic vpp_hi,
    input logic erase,
    input logic dq_drive,
    input logic busy,
    input logic pulse_err
);
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && !ce_n && !oe_n) |=> dq_drive); // R1
    AST_STANDBY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && ce_n) |=> !dq_drive); // R2
    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && !ce_n && oe_n) |=> !dq_drive); // R3
    AST_PROG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && oe_n) |=> !dq_drive); // R4
    AST_INHIBIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && ce_n) |=> !dq_drive); // R5
    AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !ce_n && !oe_n) |=> dq_drive); // R6
    AST_ERASE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase && !busy) |=> busy); // R9
    AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pulse_err)); // R10
endmodule

bind eprom_emu eprom_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .erase(erase), .dq_drive(dq_drive), .busy(busy), .pulse_err(pulse_err)
);

// File: tb/sim_eprom_emu.sv
module sim_eprom_emu;
    localparam int AW = 12, DW = 8, PMIN = 4, PMAX = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic tb_en = 1'b0;
    logic [DW-1:0] tb_v = '0;
    wire  [DW-1:0] dq;
    logic dq_drive, busy, pulse_err;

    assign dq = tb_en ? tb_v : 'z;
    always #10 clk = ~clk;

    eprom_emu #(.AW(AW), .DW(DW), .PULSE_MIN(PMIN), .PULSE_MAX(PMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .addr(addr), .dq(dq), .dq_drive(dq_drive), .erase(erase),
        .busy(busy), .pulse_err(pulse_err)
    );

    int total = 0, bad = 0, cyc = 0, busy_cnt = 0;
    bit live = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model
    logic [DW-1:0] mm [DEPTH];
    int m_cnt = 0, m_ptr = 0;
    logic [AW-1:0] m_wa = '0;
    logic [DW-1:0] m_wd = '0, m_rd = '0;
    bit m_err = 0, m_busy = 0, m_drv = 0;
    string m_tag = "R11";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_err = 0; m_busy = 0; m_drv = 0; m_tag = "R11";
        end else begin
            m_rd = mm[addr];
            if (vpp_hi) m_tag = ce_n ? "R5" : (oe_n ? "R4" : "R6");
            else        m_tag = ce_n ? "R2" : (oe_n ? "R3" : "R1");
            m_drv = !ce_n && !oe_n;
            if (m_busy) begin
                mm[m_ptr] = 8'hFF;
                if (m_ptr == DEPTH - 1) m_busy = 0;
                m_ptr++;
                m_cnt = 0;
            end else begin
                if (vpp_hi && !ce_n && oe_n) begin
                    if (m_cnt == 0) begin m_wa = addr; m_wd = tb_v; m_err = 0; end
                    if (m_cnt <= PMAX) m_cnt++;
                end else if (m_cnt != 0) begin
                    if (m_cnt >= PMIN && m_cnt <= PMAX) mm[m_wa] = mm[m_wa] & m_wd;
                    else if (m_cnt > PMAX) m_err = 1;
                    m_cnt = 0;
                end
                if (erase) begin m_busy = 1; m_ptr = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (live) begin
            chk(dq_drive == m_drv, m_tag, dq_drive, m_drv);
            if (m_drv) chk(dq == m_rd, m_tag, dq, m_rd);
            chk(busy == m_busy, "R9", busy, m_busy);
            chk(pulse_err == m_err, "R8", pulse_err, m_err);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        vpp_hi = 0; ce_n = 0; oe_n = 0; addr = a;
        @(negedge clk);
        chk(dq_drive && dq == e, tag, dq, e);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
        vpp_hi = 0; ce_n = 0; oe_n = 1;
        @(negedge clk);
        vpp_hi = 1; ce_n = 1; addr = a; tb_v = d; tb_en = 1;
        @(negedge clk);
        ce_n = 0;
        repeat (len) @(negedge clk);
        ce_n = 1;
        @(negedge clk);
        vpp_hi = 0; tb_en = 0;
        @(negedge clk);
    endtask

    task automatic start_erase();
        busy_cnt = 0;
        erase = 1;
        @(negedge clk);
        erase = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !pulse_err && !dq_drive, "R11", {busy, pulse_err, dq_drive}, 0);
        rst_n = 1; live = 1;
        @(negedge clk);

        start_erase();
        while (busy) @(negedge clk);
        chk(busy_cnt == DEPTH, "R9", busy_cnt, DEPTH);
        rd(12'd0, 8'hFF, "R9");
        rd(12'hFFF, 8'hFF, "R9");
        rd(12'd123, 8'hFF, "R9");

        ce_n = 1; oe_n = 0; @(negedge clk); @(negedge clk);
        chk(!dq_drive, "R2", dq_drive, 0);
        ce_n = 0; oe_n = 1; @(negedge clk); @(negedge clk);
        chk(!dq_drive, "R3", dq_drive, 0);

        prog(12'd5, 8'hA5, PMIN);
        rd(12'd5, 8'hA5, "R4");
        prog(12'd5, 8'h0F, PMAX);
        rd(12'd5, 8'h05, "R4");

        prog(12'd6, 8'h00, PMIN - 1);
        rd(12'd6, 8'hFF, "R7");

        prog(12'd7, 8'h00, PMAX + 1);
        chk(pulse_err, "R8", pulse_err, 1);
        rd(12'd7, 8'hFF, "R8");
        prog(12'd10, 8'h3C, PMIN + 1);
        chk(!pulse_err, "R8", pulse_err, 0);
        rd(12'd10, 8'h3C, "R8");

        vpp_hi = 1; ce_n = 1; oe_n = 1; addr = 12'd8; tb_v = 8'h00; tb_en = 1;
        repeat (20) @(negedge clk);
        vpp_hi = 0; tb_en = 0; ce_n = 0; @(negedge clk);
        rd(12'd8, 8'hFF, "R5");

        vpp_hi = 1; ce_n = 0; oe_n = 0; addr = 12'd5;
        repeat (3) @(negedge clk);
        chk(dq_drive && dq == 8'h05, "R6", dq, 8'h05);
        oe_n = 1; vpp_hi = 0; @(negedge clk);
        rd(12'd5, 8'h05, "R6");

        start_erase();
        repeat (50) @(negedge clk);
        prog(12'd9, 8'h00, PMIN);
        erase = 1; @(negedge clk); erase = 0;
        while (busy) @(negedge clk);
        chk(busy_cnt == DEPTH, "R10", busy_cnt, DEPTH);
        rd(12'd9, 8'hFF, "R10");
        rd(12'd5, 8'hFF, "R9");
        ce_n = 1; oe_n = 1; @(negedge clk); @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule